// File: doc/BRIEF.md
# Pointer-Addressed Buffer RAM Port with Read Prefetch

This block lets a host reach a 2048-byte packet buffer without ever addressing it directly. The host sees three byte-wide registers: a data register and two halves of an 11-bit buffer pointer. The high half also carries two mode bits. The auto-advance bit makes the pointer step through the buffer on every data access, which suits filling or draining a packet. The read-direction bit decides whether loading the pointer's low byte fetches a byte from the buffer at once.

Reads never wait on the buffer. Each byte the host reads is already in the data register, having been fetched ahead of time. Host writes go into the data register first and reach the buffer one cycle later. A small sequencer with four named states carries out the buffer cycles:
- `SEQ_IDLE` takes host strobes.
- `SEQ_FETCH` issues a buffer read.
- `SEQ_LOAD` captures the returned byte.
- `SEQ_STORE` issues a buffer write.

The sequencer moves through these transitions:
- idle→fetch on a pointer-low write in read direction, or on a data read with auto-advance.
- idle→store on a data write.
- fetch→load, load→idle and store→idle, each unconditionally.

Host strobes are single-cycle. Successive strobes must be at least three clock cycles apart. Strobes that arrive while the sequencer is away from idle are dropped.

The buffer itself sits outside the block. It is a single-port synchronous RAM: on a cycle with the request high, it returns read data on the following cycle.

Top module: `ptrram_port`

## Requirements
- R1: After reset, the pointer, the data register and both mode bits are zero, so reads of all three registers return 0x00.
- R2: A write to the pointer-low register (select 1) while the read-direction bit is set issues exactly one buffer read at the new pointer. Its byte is readable from the data register (select 0) three cycles after the strobe.
- R3: A write to the pointer-high register (select 2) stores the following fields, and never accesses the buffer:
  - bits [2:0] become pointer bits [10:8].
  - bit 6 becomes the auto-advance bit.
  - bit 7 becomes the read-direction bit.
- R4: A pointer-low write while the read-direction bit is clear only sets the pointer. It makes no buffer access, and the data register keeps its byte.
- R5: With auto-advance clear, a data-register read returns the held byte, makes no buffer access and leaves the pointer unchanged, however often it is repeated.
- R6: With auto-advance set, a data-register read returns the current byte, advances the pointer by one and fetches the byte at the new pointer.
- R7: A data-register write places the byte in the data register and writes it to the buffer at the pointer on the next cycle.
- R8: After a data write, the pointer advances by one if auto-advance is set and stays put if it is clear.
- R9: The pointer wraps from 0x7FF to 0x000 when it advances.
- R10: The pointer registers read back as written. Pointer-high reads as {direction, auto-advance, 000, pointer[10:8]}.
- R11: A host strobe that arrives while a buffer cycle is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 data, 1 pointer low, 2 pointer high |
| host_rd | input | 1 | Single-cycle register read strobe |
| host_wr | input | 1 | Single-cycle register write strobe |
| host_wdata | input | 8 | Write byte from host |
| host_rdata | output | 8 | Selected register contents |
| ram_req | output | 1 | Buffer cycle request |
| ram_we | output | 1 | Buffer cycle is a write |
| ram_addr | output | 11 | Buffer address (the pointer) |
| ram_wdata | output | 8 | Byte written to the buffer |
| ram_rdata | input | 8 | Byte returned by the buffer one cycle after a read request |

## Verification
Three kinds of internal fault show up directly at the ports:
- A pointer that has stepped wrongly, or not wrapped, is visible at once in the pointer readback, and in the buffer address of the next fetch or store.
- A wrongly taken sequencer transition shows as a buffer request where none belongs, counted against the buffer, or as a missing one.
- A stale or wrongly loaded data register shows in the very next data read, three cycles after the strobe that should have refreshed it.

A dropped or mis-staged write byte shows one read later, when the pointer is reloaded over that address.

// File: rtl/ptrram_pkg.sv
package ptrram_pkg;

    // Sequencer states for buffer cycles
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_LOAD  = 2'd2,
        SEQ_STORE = 2'd3
    } seq_state_t;

    // Host register select codes
    typedef enum logic [1:0] {
        REG_DATA   = 2'd0,
        REG_PTR_LO = 2'd1,
        REG_PTR_HI = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_t;

    // Bit positions of the mode flags in the pointer-high byte
    localparam int AINC_BIT = 6;
    localparam int DIR_BIT  = 7;

endpackage

// File: rtl/ptrram_ptr.sv
module ptrram_ptr
    import ptrram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic              ainc,
    output logic              rd_dir
);
    localparam int HI_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] ptr_next;

    always_comb begin
        ptr_next = ptr;
        if (lo_we) begin
            ptr_next[DATA_W-1:0] = wdata;
        end else if (hi_we) begin
            ptr_next[ADDR_W-1:DATA_W] = wdata[HI_W-1:0];
        end else if (adv) begin
            ptr_next = ptr + ONE;   // natural wrap at the top of the buffer
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            ainc   <= 1'b0;
            rd_dir <= 1'b0;
        end else begin
            ptr <= ptr_next;
            if (hi_we) begin
                ainc   <= wdata[AINC_BIT];
                rd_dir <= wdata[DIR_BIT];
            end
        end
    end

    // R9: advancing from the last address lands on zero
    assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !lo_we && !hi_we && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0));

    // R3: pointer-high write keeps the low byte
    assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !lo_we) |=> (ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0])));

endmodule

// File: rtl/ptrram_seq.sv
module ptrram_seq
    import ptrram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_data,
    input  logic       wr_data,
    input  logic       wr_lo,
    input  logic       rd_dir,
    input  logic       ainc,
    output seq_state_t state,
    output logic       accept,
    output logic       ram_req,
    output logic       ram_we,
    output logic       load_en,
    output logic       adv
);
    seq_state_t state_next;

    always_comb begin
        state_next = state;
        unique case (state)
            SEQ_IDLE: begin
                if (wr_data)                 state_next = SEQ_STORE;
                else if (wr_lo && rd_dir)    state_next = SEQ_FETCH;
                else if (rd_data && ainc)    state_next = SEQ_FETCH;
            end
            SEQ_FETCH: state_next = SEQ_LOAD;
            SEQ_LOAD:  state_next = SEQ_IDLE;
            SEQ_STORE: state_next = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_next;
    end

    always_comb begin
        accept  = 1'b0;
        ram_req = 1'b0;
        ram_we  = 1'b0;
        load_en = 1'b0;
        adv     = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                accept = 1'b1;
                adv    = rd_data && ainc && !wr_data;
            end
            SEQ_FETCH: ram_req = 1'b1;
            SEQ_LOAD:  load_en = 1'b1;
            SEQ_STORE: begin
                ram_req = 1'b1;
                ram_we  = 1'b1;
                adv     = ainc;
            end
        endcase
    end

    // R2: a fetch is always followed by a load on the next cycle
    assert_fetch_then_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_FETCH) |=> (state == SEQ_LOAD));

    // R6: an auto-advancing read starts a fetch
    assert_ainc_read_fetches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && rd_data && ainc && !wr_data) |=> (ram_req && !ram_we));

endmodule

// File: rtl/ptrram_dreg.sv
module ptrram_dreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              load_en,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= ram_rdata;
        else if (host_we) q <= host_wdata;
    end

    // R2: the load cycle captures the returned buffer byte
    assert_load_captures_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (q == $past(ram_rdata)));

    // R5: with no load and no write the held byte does not move
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !host_we) |=> $stable(q));

endmodule

// File: rtl/ptrram_port.sv
module ptrram_port
    import ptrram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int PAD_W = DATA_W - 2 - HI_W;

    seq_state_t        state;
    logic              accept;
    logic              load_en;
    logic              adv;
    logic              ainc;
    logic              rd_dir;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] hi_view;

    // Decoded, accepted host strobes
    logic wr_any, rd_any;
    logic wr_data, wr_lo, wr_hi, rd_data;

    always_comb begin
        wr_any  = host_wr && accept;
        rd_any  = host_rd && !host_wr && accept;
        wr_data = wr_any && (host_sel == REG_DATA);
        wr_lo   = wr_any && (host_sel == REG_PTR_LO);
        wr_hi   = wr_any && (host_sel == REG_PTR_HI);
        rd_data = rd_any && (host_sel == REG_DATA);
    end

    ptrram_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_data (rd_data),
        .wr_data (wr_data),
        .wr_lo   (wr_lo),
        .rd_dir  (rd_dir),
        .ainc    (ainc),
        .state   (state),
        .accept  (accept),
        .ram_req (ram_req),
        .ram_we  (ram_we),
        .load_en (load_en),
        .adv     (adv)
    );

    ptrram_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_we  (wr_lo),
        .hi_we  (wr_hi),
        .wdata  (host_wdata),
        .adv    (adv),
        .ptr    (ptr),
        .ainc   (ainc),
        .rd_dir (rd_dir)
    );

    ptrram_dreg #(.DATA_W(DATA_W)) u_dreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (wr_data),
        .host_wdata (host_wdata),
        .load_en    (load_en),
        .ram_rdata  (ram_rdata),
        .q          (data_q)
    );

    always_comb hi_view = {rd_dir, ainc, {PAD_W{1'b0}}, ptr[ADDR_W-1:DATA_W]};

    always_comb begin
        unique case (host_sel)
            REG_DATA:   host_rdata = data_q;
            REG_PTR_LO: host_rdata = ptr[DATA_W-1:0];
            REG_PTR_HI: host_rdata = hi_view;
            default:    host_rdata = '0;
        endcase
    end

    assign ram_addr  = ptr;
    assign ram_wdata = data_q;

    // R3: a pointer-high write starts no buffer cycle
    assert_hi_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && accept && host_sel == REG_PTR_HI) |=> !ram_req);

    // R4: pointer-low write in write direction starts no buffer cycle
    assert_lo_wrdir_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && accept && host_sel == REG_PTR_LO && !rd_dir) |=> !ram_req);

    // R5: plain read without auto-advance leaves pointer and buffer alone
    assert_plain_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && accept && host_sel == REG_DATA && !ainc)
        |=> (!ram_req && $stable(ram_addr)));

    // R7: a data write reaches the buffer on the next cycle at the same address
    assert_write_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && accept && host_sel == REG_DATA)
        |=> (ram_req && ram_we && ram_wdata == $past(host_wdata)
             && ram_addr == $past(ram_addr)));

    // R11: strobes during a buffer cycle leave the pointer-high view unchanged
    assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !adv) |=> $stable(hi_view));

endmodule

// File: tb/ptrram_port_tb.sv
module ptrram_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic        ram_req, ram_we;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int failures = 0;
    int ram_ops = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    ptrram_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    function automatic logic [7:0] fill(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Single-port synchronous buffer model
    logic [7:0] mem [0:2047];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= fill(i);
            ram_rdata <= 8'd0;
        end else if (ram_req) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
            ram_ops <= ram_ops + 1;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard for host reads
    logic [7:0] exp_q [$];
    string      tag_q [$];
    event       mon_ev;

    always @(mon_ev) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(32'(host_rdata), 32'(e), t);
    end

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        host_sel = sel; host_wdata = val; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [1:0] sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> mon_ev;
        @(negedge clk);
        host_rd = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ops0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(2'd1, 8'h00, "R1 ptr_lo");
        bus_read(2'd2, 8'h00, "R1 ptr_hi");
        bus_read(2'd0, 8'h00, "R1 data");

        // R3/R10: pointer-high fields, no buffer access
        ops0 = ram_ops;
        bus_write(2'd2, 8'h81);
        bus_read(2'd2, 8'h81, "R10 ptr_hi readback");
        chk(ram_ops - ops0, 0, "R3 no access on ptr_hi write");

        // R2: pointer-low write in read direction prefetches
        ops0 = ram_ops;
        bus_write(2'd1, 8'h23);
        chk(ram_ops - ops0, 1, "R2 one fetch");
        bus_read(2'd0, fill(12'h123), "R2 prefetched byte");

        // R5: repeated reads without auto-advance
        ops0 = ram_ops;
        bus_read(2'd0, fill(12'h123), "R5 repeat read 1");
        bus_read(2'd0, fill(12'h123), "R5 repeat read 2");
        chk(ram_ops - ops0, 0, "R5 no access");
        bus_read(2'd1, 8'h23, "R5 pointer held");

        // R6: auto-advancing reads
        bus_write(2'd2, 8'hC1);
        bus_write(2'd1, 8'h30);
        bus_read(2'd0, fill(12'h130), "R6 seq 0");
        bus_read(2'd0, fill(12'h131), "R6 seq 1");
        bus_read(2'd0, fill(12'h132), "R6 seq 2");
        bus_read(2'd1, 8'h33, "R6 pointer advanced");

        // R9: wrap at the top of the buffer
        bus_write(2'd2, 8'hC7);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd0, fill(12'h7FF), "R9 last byte");
        bus_read(2'd1, 8'h00, "R9 ptr_lo wrapped");
        bus_read(2'd2, 8'hC0, "R9 ptr_hi wrapped");
        bus_read(2'd0, fill(0), "R9 first byte");

        // R4: write direction, pointer-low write does not fetch
        ops0 = ram_ops;
        bus_write(2'd2, 8'h02);
        bus_write(2'd1, 8'h10);
        chk(ram_ops - ops0, 0, "R4 no access");
        bus_read(2'd0, fill(1), "R4 data kept");

        // R7/R8: data write without auto-advance
        bus_write(2'd0, 8'h5A);
        bus_read(2'd0, 8'h5A, "R7 data reg holds write");
        chk(32'(mem[11'h210]), 32'h5A, "R7 buffer written");
        bus_read(2'd1, 8'h10, "R8 pointer held");

        // R8: data writes with auto-advance
        bus_write(2'd2, 8'h42);
        bus_write(2'd0, 8'hA1);
        bus_write(2'd0, 8'hA2);
        chk(32'(mem[11'h210]), 32'hA1, "R8 first write");
        chk(32'(mem[11'h211]), 32'hA2, "R8 second write");
        bus_read(2'd1, 8'h12, "R8 pointer advanced");

        // R2/R7: read back written bytes through a fresh fetch
        bus_write(2'd2, 8'h82);
        bus_write(2'd1, 8'h10);
        bus_read(2'd0, 8'hA1, "R7 readback via fetch");

        // R11: pointer-high write during a fetch is dropped
        @(negedge clk);
        host_sel = 2'd1; host_wdata = 8'h11; host_wr = 1'b1;
        @(negedge clk);
        host_sel = 2'd2; host_wdata = 8'h00;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(2'd2, 8'h82, "R11 ptr_hi unchanged");
        bus_read(2'd0, 8'hA2, "R11 fetch completed");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule